// File: doc/BRIEF.md
# Chip-Select Memory Write Sequencer

This block runs one write access at a time to an asynchronous memory or peripheral that sits on a multiplexed address/data bus. When a request is accepted, it drives the address and pulses the address-latch enable. It then places the write data on the same bus and asserts the active-low chip-select after a programmable delay. The active-low write-enable strobe is asserted inside the chip-select window. A one-tick transfer-acknowledge pulse marks the last strobe tick. A buffer-direction output stays at one level for the whole access, so an external transceiver can steer the data onto a secondary bus.

Each request carries its own timing options: a 2-bit chip-select delay code, a 4-bit wait count, a relaxed-timing bit that doubles the wait count, and an extended-hold bit that releases write-enable early to give the memory more data hold time. All timing is counted on the block clock. One local-bus cycle spans `QTR` ticks (default 4), so quarter-cycle and half-cycle offsets are whole ticks. The request side is a valid/ready handshake. `req_ready` is high only while the sequencer is idle, and a requester holding `req_valid` high simply waits. Back-pressure lasts from acceptance until the recovery period after chip-select has finished.

Top module: `lbw_write_seq`

## Requirements
- R1: After reset, and whenever reset is applied mid-access, the outputs are idle: `ale`=0, `cs_n`=1, `we_n`=1, `ta`=0, `lad_oe`=0, `bctl`=0 and `req_ready`=1.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low from the tick after acceptance until the sequencer is idle again. While `req_valid` is low, the bus pins stay idle.
- R3: In the first `QTR` ticks after acceptance, `ale` is high and `lad_out` carries the request address with `lad_oe`=1. Chip-select is not asserted during this phase.
- R4: The delay from the fall of `ale` to the fall of `cs_n` is set by `opt_acs`: 0 ticks for codes 00 and 01, `QTR/4` ticks for code 10, and `QTR/2` ticks for code 11.
- R5: With `opt_trlx`=0, `cs_n` stays low for `QTR*(BASE_CYC + opt_scy)` ticks.
- R6: With `opt_trlx`=1, `cs_n` stays low for `QTR*(BASE_CYC + 2*opt_scy)` ticks.
- R7: `we_n` falls one tick after `cs_n` falls and is never low while `cs_n` is high. With `opt_ehtr`=0 it rises together with `cs_n`. With `opt_ehtr`=1 it rises `QTR` ticks before `cs_n` rises.
- R8: `ta` is high for exactly one tick, the last tick in which `cs_n` is low.
- R9: From the fall of `ale` until the tick after `ta` falls, `lad_out` holds the write data with `lad_oe`=1.
- R10: `bctl` is high, without change, from the tick after acceptance through the last chip-select tick.
- R11: After `cs_n` rises, it stays high for `QTR` ticks before `req_ready` returns, so no new address phase can begin sooner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, `QTR` ticks per local-bus cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write request valid |
| req_ready | output | 1 | Sequencer idle and able to accept |
| req_addr | input | W | Write address |
| req_data | input | W | Write data |
| opt_acs | input | 2 | Chip-select delay code |
| opt_scy | input | 4 | Wait count |
| opt_trlx | input | 1 | Relaxed timing, doubles the wait count |
| opt_ehtr | input | 1 | Extended hold, early write-enable release |
| lad_out | output | W | Multiplexed address/data bus value |
| lad_oe | output | 1 | Bus drive enable |
| ale | output | 1 | Address latch enable |
| cs_n | output | 1 | Chip-select, active low |
| we_n | output | 1 | Write-enable, active low |
| bctl | output | 1 | Buffer direction, high for the whole write |
| ta | output | 1 | Transfer acknowledge pulse |

## Verification
The assertions check the cycle-local rules on every tick. These are: write-enable lies inside the chip-select window, the address phase never overlaps chip-select, `bctl` covers chip-select, the acknowledge is a single tick followed by chip-select release, and the bus holds steady while write-enable is low and on the tick `ta` falls. Phase lengths are absolute tick counts that depend on the options: the chip-select delay, the strobe length with and without relaxed timing, the early write-enable release, and the recovery before ready returns. Only the bench's scenarios show these, by measuring each access over its option combination.

// File: rtl/lbw_pkg.sv
package lbw_pkg;
  localparam int SCY_W = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ALE,
    ST_ACS,
    ST_STRB,
    ST_RECOV
  } lbw_state_e;

  typedef struct packed {
    logic [1:0]       acs;
    logic [SCY_W-1:0] scy;
    logic             trlx;
    logic             ehtr;
  } lbw_opt_t;
endpackage

// File: rtl/lbw_timing.sv
module lbw_timing
  import lbw_pkg::*;
#(
  parameter int QTR      = 4,
  parameter int BASE_CYC = 2,
  parameter int CNT_W    = 8
) (
  input  lbw_opt_t         opt,
  output logic [CNT_W-1:0] acs_ticks,
  output logic [CNT_W-1:0] strb_ticks
);
  localparam int QUARTER = QTR / 4;
  localparam int HALF    = QTR / 2;

  logic [CNT_W-1:0] nwait;

  always_comb begin
    unique case (opt.acs)
      2'b10:   acs_ticks = CNT_W'(QUARTER);
      2'b11:   acs_ticks = CNT_W'(HALF);
      default: acs_ticks = '0;
    endcase
  end

  generate
    if (QTR % 4 != 0) begin : g_bad_qtr
      initial $display("lbw_timing: QTR should be a multiple of 4");
    end
  endgenerate

  always_comb begin
    nwait      = opt.trlx ? CNT_W'({opt.scy, 1'b0}) : CNT_W'(opt.scy);
    strb_ticks = CNT_W'(QTR) * (CNT_W'(BASE_CYC) + nwait);
  end
endmodule

// File: rtl/lbw_fsm.sv
module lbw_fsm
  import lbw_pkg::*;
#(
  parameter int QTR   = 4,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [CNT_W-1:0] acs_ticks,
  input  logic [CNT_W-1:0] strb_ticks,
  output logic             req_ready,
  output logic             accept,
  output lbw_state_e       state,
  output logic [CNT_W-1:0] cnt
);
  lbw_state_e       state_nx;
  logic [CNT_W-1:0] cnt_nx;
  logic             last;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign last      = (cnt == '0);

  always_comb begin
    state_nx = state;
    cnt_nx   = last ? cnt : cnt - CNT_W'(1);
    unique case (state)
      ST_IDLE: if (req_valid) begin
        state_nx = ST_ALE;
        cnt_nx   = CNT_W'(QTR - 1);
      end
      ST_ALE: if (last) begin
        if (acs_ticks == '0) begin
          state_nx = ST_STRB;
          cnt_nx   = strb_ticks - CNT_W'(1);
        end else begin
          state_nx = ST_ACS;
          cnt_nx   = acs_ticks - CNT_W'(1);
        end
      end
      ST_ACS: if (last) begin
        state_nx = ST_STRB;
        cnt_nx   = strb_ticks - CNT_W'(1);
      end
      ST_STRB: if (last) begin
        state_nx = ST_RECOV;
        cnt_nx   = CNT_W'(QTR - 1);
      end
      ST_RECOV: if (last) state_nx = ST_IDLE;
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= state_nx;
      cnt   <= cnt_nx;
    end
  end

  // R2
  accept_backpressure_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  // R11
  recovery_before_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STRB && last) |=> !req_ready);
endmodule

// File: rtl/lbw_pins.sv
module lbw_pins
  import lbw_pkg::*;
#(
  parameter int W     = 32,
  parameter int QTR   = 4,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  lbw_state_e       state,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] strb_ticks,
  input  logic             ehtr,
  input  logic [W-1:0]     addr,
  input  logic [W-1:0]     data,
  output logic [W-1:0]     lad_out,
  output logic             lad_oe,
  output logic             ale,
  output logic             cs_n,
  output logic             we_n,
  output logic             bctl,
  output logic             ta
);
  logic in_ale, in_acs, in_strb, in_recov, first_tick, hold_ok, recov_first;

  always_comb begin
    in_ale      = (state == ST_ALE);
    in_acs      = (state == ST_ACS);
    in_strb     = (state == ST_STRB);
    in_recov    = (state == ST_RECOV);
    first_tick  = (cnt == strb_ticks - CNT_W'(1));
    hold_ok     = !ehtr || (cnt >= CNT_W'(QTR));
    recov_first = in_recov && (cnt == CNT_W'(QTR - 1));

    ale     = in_ale;
    cs_n    = !in_strb;
    we_n    = !(in_strb && !first_tick && hold_ok);
    ta      = in_strb && (cnt == '0);
    bctl    = in_ale || in_acs || in_strb;
    lad_oe  = in_ale || in_acs || in_strb || recov_first;
    lad_out = in_ale ? addr : (lad_oe ? data : '0);
  end

  // R7
  we_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !cs_n);

  // R3
  ale_no_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (cs_n && we_n && lad_oe));

  // R8
  ta_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ta |=> (!ta && cs_n));

  // R9
  data_after_ta_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ta) |-> (lad_oe && $stable(lad_out)));

  // R9
  data_steady_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n && $past(!we_n)) |-> (lad_oe && $stable(lad_out)));

  // R10
  bctl_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> bctl);
endmodule

// File: rtl/lbw_write_seq.sv
module lbw_write_seq
  import lbw_pkg::*;
#(
  parameter int W        = 32,
  parameter int QTR      = 4,
  parameter int BASE_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [W-1:0]     req_addr,
  input  logic [W-1:0]     req_data,
  input  logic [1:0]       opt_acs,
  input  logic [SCY_W-1:0] opt_scy,
  input  logic             opt_trlx,
  input  logic             opt_ehtr,
  output logic [W-1:0]     lad_out,
  output logic             lad_oe,
  output logic             ale,
  output logic             cs_n,
  output logic             we_n,
  output logic             bctl,
  output logic             ta
);
  localparam int MAX_TICKS = QTR * (BASE_CYC + 2 * ((1 << SCY_W) - 1));
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);

  lbw_opt_t         opt_q;
  logic [W-1:0]     addr_q, data_q;
  logic [CNT_W-1:0] acs_ticks, strb_ticks, cnt;
  logic             accept;
  lbw_state_e       state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opt_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else if (accept) begin
      opt_q  <= '{acs: opt_acs, scy: opt_scy, trlx: opt_trlx, ehtr: opt_ehtr};
      addr_q <= req_addr;
      data_q <= req_data;
    end
  end

  lbw_timing #(.QTR(QTR), .BASE_CYC(BASE_CYC), .CNT_W(CNT_W)) u_timing (
    .opt        (opt_q),
    .acs_ticks  (acs_ticks),
    .strb_ticks (strb_ticks)
  );

  lbw_fsm #(.QTR(QTR), .CNT_W(CNT_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .acs_ticks  (acs_ticks),
    .strb_ticks (strb_ticks),
    .req_ready  (req_ready),
    .accept     (accept),
    .state      (state),
    .cnt        (cnt)
  );

  lbw_pins #(.W(W), .QTR(QTR), .CNT_W(CNT_W)) u_pins (
    .clk        (clk),
    .rst_n      (rst_n),
    .state      (state),
    .cnt        (cnt),
    .strb_ticks (strb_ticks),
    .ehtr       (opt_q.ehtr),
    .addr       (addr_q),
    .data       (data_q),
    .lad_out    (lad_out),
    .lad_oe     (lad_oe),
    .ale        (ale),
    .cs_n       (cs_n),
    .we_n       (we_n),
    .bctl       (bctl),
    .ta         (ta)
  );
endmodule

// File: tb/tb_lbw_write_seq.sv
`timescale 1ns/1ps
module tb_lbw_write_seq;
  localparam int W = 32;
  localparam int QTR = 4;
  localparam int BASE = 2;
  localparam int NV = 10;
  // fields: acs[2] scy[4] trlx ehtr addr[32] data[32]
  localparam logic [71:0] VECS [NV] = '{
    {2'b00, 4'd0,  1'b0, 1'b0, 32'h0000_1000, 32'hA5A5_0001},
    {2'b01, 4'd1,  1'b0, 1'b0, 32'h0000_2004, 32'h5A5A_0002},
    {2'b10, 4'd2,  1'b0, 1'b1, 32'h0000_3008, 32'h1234_5678},
    {2'b11, 4'd3,  1'b0, 1'b0, 32'hFFFF_FFFC, 32'h8765_4321},
    {2'b00, 4'd1,  1'b1, 1'b0, 32'h0123_4567, 32'hDEAD_BEEF},
    {2'b10, 4'd3,  1'b1, 1'b1, 32'h89AB_CDEF, 32'hCAFE_F00D},
    {2'b11, 4'd0,  1'b1, 1'b1, 32'h0000_0010, 32'h0000_0000},
    {2'b11, 4'd15, 1'b1, 1'b1, 32'h7777_0000, 32'hFFFF_FFFF},
    {2'b01, 4'd15, 1'b0, 1'b0, 32'h0F0F_0F0F, 32'hF0F0_F0F0},
    {2'b00, 4'd0,  1'b1, 1'b1, 32'h1111_2222, 32'h3333_4444}
  };

  logic clk = 1'b0, rst_n = 1'b0, req_valid = 1'b0;
  logic [W-1:0] req_addr = '0, req_data = '0;
  logic [1:0] opt_acs = '0;
  logic [3:0] opt_scy = '0;
  logic opt_trlx = 1'b0, opt_ehtr = 1'b0;
  logic req_ready, lad_oe, ale, cs_n, we_n, bctl, ta;
  logic [W-1:0] lad_out;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  lbw_write_seq #(.W(W), .QTR(QTR), .BASE_CYC(BASE)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .opt_acs(opt_acs), .opt_scy(opt_scy),
    .opt_trlx(opt_trlx), .opt_ehtr(opt_ehtr), .lad_out(lad_out), .lad_oe(lad_oe),
    .ale(ale), .cs_n(cs_n), .we_n(we_n), .bctl(bctl), .ta(ta));

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_idle(input string req);
    check(req, {ale, cs_n, we_n, ta, lad_oe, bctl, req_ready}, 7'b0110001);
  endtask

  task automatic run_access(input logic [1:0] acs, input logic [3:0] scy,
                            input logic trlx, input logic ehtr,
                            input logic [W-1:0] a, input logic [W-1:0] d);
    int acs_e, s_e, t, ale_n, ale_last, cs_first, cs_n_low, cs_rise, we_first, we_n_low;
    int we_last, ta_n, ta_t, addr_bad, data_bad, bctl_bad, rdy_t, we_out;
    acs_e = (acs == 2'b10) ? QTR/4 : (acs == 2'b11) ? QTR/2 : 0;
    s_e = QTR * (BASE + (trlx ? 2*scy : scy));
    ale_n = 0; ale_last = -1; cs_first = -1; cs_n_low = 0; cs_rise = -1; we_first = -1;
    we_n_low = 0; we_last = -1; ta_n = 0; ta_t = -1; addr_bad = 0; data_bad = 0;
    bctl_bad = 0; rdy_t = -1; we_out = 0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_data = d;
    opt_acs = acs; opt_scy = scy; opt_trlx = trlx; opt_ehtr = ehtr;
    @(negedge clk);
    req_valid = 1'b0; req_addr = '0; req_data = '0; opt_acs = '0; opt_scy = '0;
    opt_trlx = 1'b0; opt_ehtr = 1'b0;
    for (t = 0; t < 400; t++) begin
      if (ale) begin ale_n++; ale_last = t; if (lad_out != a || !lad_oe) addr_bad++; end
      if (!cs_n) begin if (cs_first < 0) cs_first = t; cs_n_low++; end
      if (cs_n && cs_first >= 0 && cs_rise < 0) cs_rise = t;
      if (!we_n) begin if (we_first < 0) we_first = t; we_n_low++; we_last = t;
        if (cs_n) we_out++; end
      if (ta) begin ta_n++; ta_t = t; end
      if (t >= QTR && t <= QTR + acs_e + s_e && (lad_out != d || !lad_oe)) data_bad++;
      if (t <= QTR + acs_e + s_e - 1 && !bctl) bctl_bad++;
      if (req_ready) begin rdy_t = t; break; end
      @(negedge clk);
    end
    check("R3 ale ticks", ale_n, QTR);
    check("R3 ale last tick", ale_last, QTR-1);
    check("R3 address on bus", addr_bad, 0);
    check("R4 cs delay", cs_first, QTR + acs_e);
    check(trlx ? "R6 cs low ticks" : "R5 cs low ticks", cs_n_low, s_e);
    check("R7 we first", we_first, QTR + acs_e + 1);
    check("R7 we low ticks", we_n_low, s_e - 1 - (ehtr ? QTR : 0));
    check("R7 we outside cs", we_out, 0);
    check("R8 ta count", ta_n, 1);
    check("R8 ta tick", ta_t, QTR + acs_e + s_e - 1);
    check("R9 data held", data_bad, 0);
    check("R10 bctl steady", bctl_bad, 0);
    check("R11 ready after recovery", rdy_t, cs_rise + QTR);
    check("R2 busy span", rdy_t, 2*QTR + acs_e + s_e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_idle("R1 reset outputs");
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1 after release");
    for (int i = 0; i < NV; i++)
      run_access(VECS[i][71:70], VECS[i][69:66], VECS[i][65], VECS[i][64],
                 VECS[i][63:32], VECS[i][31:0]);
    // R2: no valid, no activity
    begin
      int act;
      act = 0;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (ale || !cs_n || !we_n || lad_oe || ta) act++;
      end
      check("R2 idle without valid", act, 0);
    end
    // R1: reset mid-strobe
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h55; req_data = 32'h66; opt_scy = 4'd5;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (QTR + 3) @(negedge clk);
    check("R1 mid-access strobe active", cs_n, 0);
    rst_n = 1'b0;
    #1;
    check_idle("R1 reset mid-access");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1 recovered from reset");
    run_access(2'b11, 4'd2, 1'b1, 1'b0, 32'hABCD_0000, 32'h0000_ABCD);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule